// File: doc/BRIEF.md
# Sample Nibble Packetizer for a Narrow Host Link

The block turns one sampling instant of a data-acquisition front end into a stream of bytes for a byte-wide host link, such as a parallel USB FIFO or a serial port. A sample-tick strobe freezes the sixteen 12-bit analog channel words and the 12-bit digital input word into holding registers. The block then emits them as a sequence of self-describing bytes. Each byte has a type flag, a small reassembly index and one 4-bit nibble of sample data. Before each analog channel's data, a marker byte names the channel, so the host can rebuild every sample without any extra framing.

The byte stream leaves through a valid/ready handshake, and the sink can stall it at any byte. The scan rate is set by the tick, nominally 20,000 scans per second. A tick that arrives while a scan is still being emitted is discarded and raises a sticky overrun flag. The flag stays set until a dedicated clear input is pulsed.

Top module: `daq_nibble_packer`

## Requirements
- R1: Every byte has this layout. Bit 7 is the type flag (1 for analog, 0 for digital). Bits 6:4 are the fragment index. Bits 3:0 are one data nibble.
- R2: Each analog channel's data is preceded by exactly one marker byte, 0xF0 plus the channel number (0xF0 to 0xFF).
- R3: A 12-bit analog sample is sent as three bytes with bit 7 = 1 and indices 0, 1, 2. Index 0 carries bits 11:8, index 1 carries bits 7:4 and index 2 carries bits 3:0. Analog data never uses index 7. Channel c is read from bits [12c+11:12c] of the flat analog input.
- R4: The digital word is sent after the last analog channel as three bytes with bit 7 = 0 and indices 0, 1, 2, most significant nibble first, with no marker before them.
- R5: A scan emits channels 0 to 15 in ascending order, each as marker then data, and then the digital bytes. That is 67 bytes in total. Valid drops in the cycle after the 67th byte is accepted.
- R6: A tick seen while the block is idle makes valid high in the next cycle, with the byte 0xF0.
- R7: While valid is high and ready is low, the byte and valid stay unchanged in the next cycle.
- R8: All bytes of a scan come from the input values present in the tick cycle. Later input changes have no effect on that scan.
- R9: A tick seen while a scan is in progress is dropped and sets the overrun flag. The ongoing scan continues unchanged and is not restarted.
- R10: The overrun flag stays set until the clear input is high. If a dropped tick and a clear fall in the same cycle, the flag ends up set.
- R11: After reset, valid and the overrun flag are low.
- R12: A tick in the same cycle as the handshake of the 67th byte is dropped and sets overrun. Valid then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Sample-tick strobe, one cycle |
| an_flat_i | input | 192 | Sixteen 12-bit analog words, channel c at [12c+11:12c] |
| dig_i | input | 12 | Digital input word |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| pkt_ready_i | input | 1 | Sink accepts the current byte |
| pkt_valid_o | output | 1 | A byte is offered |
| pkt_byte_o | output | 8 | Output byte |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
Two events can land in the same cycle. The first is a tick together with the acceptance of the final byte: the bench raises the tick exactly when it accepts byte 67, then checks that valid stays low and overrun is set. The second is a dropped tick together with a clear: the bench asserts both while a scan runs, and expects the flag to read high afterwards. Stalls from ready patterns and input changes during a scan are judged byte by byte against a model built from the captured snapshot.

// File: rtl/daq_pkt_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the nibble packetizer: byte layout and marker code.
// Assumes 4-bit data nibbles and a 3-bit fragment index.
package daq_pkt_pkg;
    localparam int NIB_W   = 4;
    localparam int IDX_W   = 3;
    localparam logic [NIB_W-1:0] MARK_HI = 4'hF;

    typedef struct packed {
        logic             kind;   // 1 analog, 0 digital
        logic [IDX_W-1:0] idx;    // fragment index
        logic [NIB_W-1:0] nib;    // data nibble
    } pkt_byte_t;
endpackage

// File: rtl/daq_snap_reg.sv
`timescale 1ns/1ps
// Holding registers: freeze all channel words on an accepted tick.
// Assumes cap_i is high for one cycle when a scan starts.
module daq_snap_reg #(
    parameter int N_AN = 16,
    parameter int AN_W = 12,
    parameter int DG_W = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 cap_i,
    input  logic [N_AN*AN_W-1:0] an_flat_i,
    input  logic [DG_W-1:0]      dig_i,
    output logic [AN_W-1:0]      an_q [N_AN],
    output logic [DG_W-1:0]      dig_q
);
    for (genvar c = 0; c < N_AN; c++) begin : g_ch
        // Capture one analog channel word.
        always_ff @(posedge clk_i) begin
            if (!rst_ni)    an_q[c] <= '0;
            else if (cap_i) an_q[c] <= an_flat_i[c*AN_W +: AN_W];
        end
    end

    // Capture the digital word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    dig_q <= '0;
        else if (cap_i) dig_q <= dig_i;
    end
endmodule

// File: rtl/daq_scan_seq.sv
`timescale 1ns/1ps
// Scan sequencer: walks analog channels (marker + nibbles) then digital nibbles.
// Assumes a step happens only on a valid/ready handshake; ch == N_AN means digital.
module daq_scan_seq #(
    parameter int N_AN   = 16,
    parameter int NA     = 3,
    parameter int ND     = 3,
    parameter int CH_W   = 5,
    parameter int SLOT_W = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              ready_i,
    output logic              active_o,
    output logic              start_o,
    output logic              drop_o,
    output logic [CH_W-1:0]   ch_o,
    output logic [SLOT_W-1:0] slot_o
);
    logic is_dig;

    assign start_o = tick_i && !active_o;
    assign drop_o  = tick_i && active_o;
    assign is_dig  = (ch_o == CH_W'(N_AN));

    // Advance channel/slot counters on each accepted byte.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            active_o <= 1'b0;
            ch_o     <= '0;
            slot_o   <= '0;
        end else if (start_o) begin
            active_o <= 1'b1;
            ch_o     <= '0;
            slot_o   <= '0;
        end else if (active_o && ready_i) begin
            if (!is_dig) begin
                if (slot_o == SLOT_W'(NA)) begin
                    ch_o   <= ch_o + 1'b1;
                    slot_o <= '0;
                end else begin
                    slot_o <= slot_o + 1'b1;
                end
            end else if (slot_o == SLOT_W'(ND - 1)) begin
                active_o <= 1'b0;
                ch_o     <= '0;
                slot_o   <= '0;
            end else begin
                slot_o <= slot_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/daq_byte_fmt.sv
`timescale 1ns/1ps
// Byte formatter: builds marker or data byte from scan position and held data.
// Assumes slot 0 of an analog channel is its marker; nibbles go MS first.
module daq_byte_fmt
    import daq_pkt_pkg::*;
#(
    parameter int N_AN   = 16,
    parameter int AN_W   = 12,
    parameter int DG_W   = 12,
    parameter int CH_W   = 5,
    parameter int SLOT_W = 2
) (
    input  logic [CH_W-1:0]   ch_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [AN_W-1:0]   an_q [N_AN],
    input  logic [DG_W-1:0]   dig_q,
    output pkt_byte_t         byte_o
);
    localparam int CI_W = $clog2(N_AN);

    logic [AN_W-1:0] an_sel;
    int              ai;
    int              di;

    assign an_sel = an_q[ch_i[CI_W-1:0]];

    // Select marker, analog nibble or digital nibble.
    always_comb begin
        ai = int'(slot_i) - 1;
        di = int'(slot_i);
        if (ch_i == CH_W'(N_AN)) begin
            byte_o.kind = 1'b0;
            byte_o.idx  = IDX_W'(di);
            byte_o.nib  = NIB_W'(dig_q >> (DG_W - NIB_W * (di + 1)));
        end else if (slot_i == '0) begin
            byte_o.kind = 1'b1;
            byte_o.idx  = MARK_HI[IDX_W-1:0];
            byte_o.nib  = NIB_W'(ch_i);
        end else begin
            byte_o.kind = 1'b1;
            byte_o.idx  = IDX_W'(ai);
            byte_o.nib  = NIB_W'(an_sel >> (AN_W - NIB_W * (ai + 1)));
        end
    end
endmodule

// File: rtl/daq_ovr_flag.sv
`timescale 1ns/1ps
// Sticky overrun flag: set by a dropped tick, cleared by clr_i; set wins.
module daq_ovr_flag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic drop_i,
    input  logic clr_i,
    output logic ovr_o
);
    // Hold the flag until an explicit clear without a new drop.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     ovr_o <= 1'b0;
        else if (drop_i) ovr_o <= 1'b1;
        else if (clr_i)  ovr_o <= 1'b0;
    end
endmodule

// File: rtl/daq_nibble_packer.sv
`timescale 1ns/1ps
// Top: snapshot on tick, then stream marker/nibble bytes over valid/ready.
// Assumes sample widths are multiples of 4 and at most 7 analog nibbles.
module daq_nibble_packer
    import daq_pkt_pkg::*;
#(
    parameter int N_AN = 16,
    parameter int AN_W = 12,
    parameter int DG_W = 12
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic [N_AN*AN_W-1:0] an_flat_i,
    input  logic [DG_W-1:0]      dig_i,
    input  logic                 ovr_clr_i,
    input  logic                 pkt_ready_i,
    output logic                 pkt_valid_o,
    output logic [7:0]           pkt_byte_o,
    output logic                 overrun_o
);
    localparam int NA     = AN_W / NIB_W;
    localparam int ND     = DG_W / NIB_W;
    localparam int CH_W   = $clog2(N_AN + 1);
    localparam int SLOT_W = $clog2(((NA + 1) > ND) ? (NA + 1) : ND);

    logic              start, drop;
    logic [CH_W-1:0]   ch;
    logic [SLOT_W-1:0] slot;
    logic [AN_W-1:0]   an_q [N_AN];
    logic [DG_W-1:0]   dig_q;
    pkt_byte_t         fmt_byte;

    daq_scan_seq #(.N_AN(N_AN), .NA(NA), .ND(ND), .CH_W(CH_W), .SLOT_W(SLOT_W)) u_seq (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ready_i(pkt_ready_i),
        .active_o(pkt_valid_o), .start_o(start), .drop_o(drop), .ch_o(ch), .slot_o(slot)
    );

    daq_snap_reg #(.N_AN(N_AN), .AN_W(AN_W), .DG_W(DG_W)) u_snap (
        .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(start),
        .an_flat_i(an_flat_i), .dig_i(dig_i), .an_q(an_q), .dig_q(dig_q)
    );

    daq_byte_fmt #(.N_AN(N_AN), .AN_W(AN_W), .DG_W(DG_W), .CH_W(CH_W), .SLOT_W(SLOT_W)) u_fmt (
        .ch_i(ch), .slot_i(slot), .an_q(an_q), .dig_q(dig_q), .byte_o(fmt_byte)
    );

    daq_ovr_flag u_ovr (
        .clk_i(clk_i), .rst_ni(rst_ni), .drop_i(drop), .clr_i(ovr_clr_i), .ovr_o(overrun_o)
    );

    assign pkt_byte_o = fmt_byte;
endmodule

// File: rtl/daq_pkt_chk.sv
`timescale 1ns/1ps
// Checker for the packetizer's port-level protocol; bound to the top.
module daq_pkt_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       tick_i,
    input logic       ovr_clr_i,
    input logic       pkt_ready_i,
    input logic       pkt_valid_o,
    input logic [7:0] pkt_byte_o,
    input logic       overrun_o
);
    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_valid_o && !pkt_ready_i |=> pkt_valid_o && $stable(pkt_byte_o)); // R7

    AST_START_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i && !pkt_valid_o |=> pkt_valid_o && pkt_byte_o == 8'hF0); // R6

    AST_MARKER_THEN_IDX0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_valid_o && pkt_ready_i && pkt_byte_o[7:4] == 4'hF
        |=> pkt_valid_o && pkt_byte_o[7:4] == 4'h8); // R2

    AST_DROP_SETS_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i && pkt_valid_o |=> overrun_o); // R9

    AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o && !ovr_clr_i |=> overrun_o); // R10

    AST_DIG_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pkt_valid_o && pkt_ready_i && pkt_byte_o[7:4] == 4'h2 |=> !pkt_valid_o); // R5
endmodule

bind daq_nibble_packer daq_pkt_chk u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .ovr_clr_i(ovr_clr_i),
    .pkt_ready_i(pkt_ready_i), .pkt_valid_o(pkt_valid_o),
    .pkt_byte_o(pkt_byte_o), .overrun_o(overrun_o)
);

// File: tb/sim_daq_nibble_packer.sv
`timescale 1ns/1ps
module sim_daq_nibble_packer;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [191:0] an_flat = '0;
    logic [11:0]  dig = '0;
    logic         clr = 1'b0;
    logic         ready = 1'b0;
    logic         valid;
    logic [7:0]   pbyte;
    logic         ovr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [11:0] s_an [16];
    logic [11:0] s_dig;

    always #2.5 clk = ~clk;

    daq_nibble_packer u0 (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .an_flat_i(an_flat), .dig_i(dig),
        .ovr_clr_i(clr), .pkt_ready_i(ready), .pkt_valid_o(valid),
        .pkt_byte_o(pbyte), .overrun_o(ovr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Expected k-th byte of a scan from the captured snapshot (R1-style model).
    function automatic logic [7:0] exp_byte(input int k);
        int ch, sl;
        if (k < 64) begin
            ch = k / 4; sl = k % 4;
            if (sl == 0) return {4'hF, 4'(ch)};
            return {1'b1, 3'(sl - 1), 4'(s_an[ch] >> (8 - 4 * (sl - 1)))};
        end
        sl = k - 64;
        return {1'b0, 3'(sl), 4'(s_dig >> (8 - 4 * sl))};
    endfunction

    task automatic load_random();
        for (int c = 0; c < 16; c++) an_flat[c*12 +: 12] = 12'($urandom);
        dig = 12'($urandom);
    endtask

    // Start a scan and collect all 67 bytes; options for stall, input change, extra ticks.
    task automatic run_scan(input int stall, input bit mutate, input bit mid_tick,
                            input bit end_tick, input string tag);
        int k = 0;
        int cyc = 0;
        bit rdy;
        bit stalled = 1'b0;
        logic [7:0] prev = '0;
        @(negedge clk);
        tick = 1'b1;
        for (int c = 0; c < 16; c++) s_an[c] = an_flat[c*12 +: 12];
        s_dig = dig;
        @(negedge clk);
        tick = 1'b0;
        if (mutate) begin
            an_flat = ~an_flat;
            dig = ~dig;
        end
        chk(valid && pbyte == 8'hF0, {"R6 first byte ", tag}, pbyte, 8'hF0);
        while (k < 67 && cyc < 1000) begin
            if (stalled) chk(valid && pbyte == prev, {"R7 stall hold ", tag}, pbyte, prev);
            case (stall)
                1: rdy = (cyc % 2) == 1;
                2: rdy = (cyc % 3) != 0;
                default: rdy = 1'b1;
            endcase
            if (end_tick && k == 66) rdy = 1'b1;
            chk(valid && pbyte == exp_byte(k),
                $sformatf("R1 R2 R3 R4 R8 byte %0d %s", k, tag), pbyte, exp_byte(k));
            ready = rdy;
            if (mid_tick && cyc == 10) tick = 1'b1;
            if (end_tick && k == 66) tick = 1'b1;
            if (rdy) k++;
            stalled = !rdy;
            prev = pbyte;
            @(negedge clk);
            tick = 1'b0;
            ready = 1'b0;
            cyc++;
        end
        chk(k == 67, {"R5 byte count ", tag}, k, 67);
        chk(!valid, {"R5 valid drops ", tag}, valid, 0);
        if (mid_tick) chk(ovr, {"R9 overrun set ", tag}, ovr, 1);
        if (end_tick) chk(ovr, {"R12 overrun set ", tag}, ovr, 1);
        @(negedge clk);
        chk(!valid, {"R12 no restart ", tag}, valid, 0);
    endtask

    task automatic t_reset();
        chk(!valid, "R11 valid after reset", valid, 0);
        chk(!ovr, "R11 overrun after reset", ovr, 0);
    endtask

    task automatic t_clear();
        @(negedge clk); @(negedge clk);
        chk(ovr, "R10 sticky", ovr, 1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(!ovr, "R10 cleared", ovr, 0);
        // dropped tick and clear in the same cycle: set wins
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk(valid && !ovr, "R10 scan started", valid, 1);
        tick = 1'b1;
        clr = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        clr = 1'b0;
        chk(ovr, "R10 set wins over clear", ovr, 1);
        ready = 1'b1;
        for (int i = 0; i < 80 && valid; i++) @(negedge clk);
        ready = 1'b0;
        chk(!valid, "R5 drained", valid, 0);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk(!ovr, "R10 final clear", ovr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        load_random();
        run_scan(0, 1'b0, 1'b0, 1'b0, "plain");
        chk(!ovr, "R9 no overrun on clean scan", ovr, 0);
        load_random();
        run_scan(1, 1'b1, 1'b0, 1'b0, "alternate stall, inputs changed");
        load_random();
        run_scan(2, 1'b0, 1'b1, 1'b0, "tick mid scan");
        t_clear();
        an_flat = '1; dig = 12'hABC;
        run_scan(0, 1'b0, 1'b0, 1'b1, "tick on last handshake");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule